// File: doc/BRIEF.md
# NAND Page Read Sequencer

This block drives the pins of an 8-bit, small-page NAND flash device to carry out one read operation per request. There are two operations. The first is a spare-area probe, which fetches the single bad-block marker byte of a page. The second is a data-page read, which fetches every byte of the page's main area. For both, the block produces a command cycle and then a string of address cycles. It then waits for the device to finish its array access and pulses the read strobe once per byte. Each returned byte is forwarded on a valid/ready byte stream.

A controller hands over a request with the operation type and a 20-bit page address. The request is taken only while the sequencer is idle. Strobe timing is set by parameters counted in clock cycles: setup, write low width, write high width, the delay before the busy line is trusted, read low width and read high width. The wait after addressing uses one of two methods, chosen by a parameter: poll the device's ready/busy line, or count a fixed number of cycles. A further parameter adds a fourth address cycle for devices above 32 MiB. A one-cycle done pulse closes every operation.

Top module: `nand_page_reader`

## Requirements
- R1: After reset and whenever idle, chip enable is high, both latch enables are low, both strobes are high, `req_ready` is 1, `out_valid` is 0 and `done` is 0.
- R2: Every operation opens with one byte written while `nand_cle` is high. The byte is 0x00 for a page read (`req_spare`=0) and 0x50 for a spare probe (`req_spare`=1).
- R3: After the command, bytes are written while `nand_ale` is high, in this order: column, page[7:0], page[15:8]. The column is 0 for a page read and MARK_COL for a spare probe. `nand_ale` is low once the address is complete.
- R4: With ADDR4=1, a fourth address byte {4'h0, page[19:16]} follows. With ADDR4=0, exactly three address bytes are sent.
- R5: `nand_cle` and `nand_ale` are never high together, and `nand_we_n` and `nand_re_n` are never low together.
- R6: With USE_RB=1, no read strobe falls until T_WB cycles have passed after `nand_ale` falls and `nand_rb` has been sampled high.
- R7: With USE_RB=0, `nand_rb` is ignored and the first read strobe falls exactly T_WB+WAIT_CYC cycles after `nand_ale` falls.
- R8: A page read yields exactly PAGE_SIZE bytes and a spare probe yields exactly one byte. `out_last` is high only with the final byte.
- R9: Each output byte is the value on `nand_dq_i` at the clock edge on which `nand_re_n` rises.
- R10: While `out_valid` is high and `out_ready` is low, `out_data` is held and no new read strobe starts.
- R11: `done` is high for exactly one cycle, in the cycle after the final byte is accepted, and the block is idle at that point.
- R12: A request presented while an operation is in progress is ignored; the operation running continues unchanged.
- R13: Every write strobe is low for exactly T_WP cycles and every read strobe is low for exactly T_RP cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | High when idle and able to take a request |
| req_spare | input | 1 | 1 = spare marker probe, 0 = page read |
| req_page | input | 20 | Page address |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Byte driven to the device |
| nand_dq_oe | output | 1 | Output enable for `nand_dq_o` |
| nand_dq_i | input | 8 | Byte from the device |
| nand_rb | input | 1 | Device ready (1) / busy (0) |
| out_valid | output | 1 | Read byte available |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | 8 | Read byte |
| out_last | output | 1 | Final byte of the operation |
| done | output | 1 | One-cycle end-of-operation pulse |

## Verification
A read byte appears on the stream on the same edge that raises the read strobe, and `done` follows one cycle after the final stream handshake. The bench therefore changes `out_ready` at the falling edge, records a byte only when valid and ready are both high there, and samples `done` and `req_ready` at the next two falling edges. The fixed-delay wait is checked by its exact span from the fall of the address latch to the first read-strobe fall, T_WB+WAIT_CYC cycles, as measured by timestamps in the device model. Strobe widths and the absence of reads during busy are measured against the same timestamps.

// File: rtl/nand_page_reader.sv
`timescale 1ns/1ps
module nand_page_reader #(
  parameter int PAGE_SIZE = 512,
  parameter int ADDR4     = 0,
  parameter int USE_RB    = 1,
  parameter int WAIT_CYC  = 64,
  parameter int MARK_COL  = 5,
  parameter int T_SU      = 1,
  parameter int T_WP      = 2,
  parameter int T_WH      = 2,
  parameter int T_WB      = 4,
  parameter int T_RP      = 2,
  parameter int T_REH     = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_spare,
  input  logic [19:0] req_page,
  output logic        nand_ce_n,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic        nand_re_n,
  output logic [7:0]  nand_dq_o,
  output logic        nand_dq_oe,
  input  logic [7:0]  nand_dq_i,
  input  logic        nand_rb,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        out_last,
  output logic        done
);

  localparam int LAST_B = (ADDR4 != 0) ? 4 : 3;
  localparam int TSUM   = WAIT_CYC + T_SU + T_WP + T_WH + T_WB + T_RP + T_REH;
  localparam int CW     = $clog2(TSUM + 1);
  localparam int RW     = $clog2(PAGE_SIZE + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_WSU, S_WLO, S_WHI, S_TWB, S_WAIT, S_RLO, S_RHI
  } st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic [2:0]    bidx;
  logic          spare_q;
  logic [19:0]   page_q;
  logic [RW-1:0] rem;
  logic [7:0]    wbyte;
  logic          wr_phase;
  logic          tick;

  assign tick     = (cnt == '0);
  assign wr_phase = (st == S_WSU) || (st == S_WLO) || (st == S_WHI);

  always_comb begin
    case (bidx)
      3'd0:    wbyte = spare_q ? 8'h50 : 8'h00;
      3'd1:    wbyte = spare_q ? 8'(MARK_COL) : 8'h00;
      3'd2:    wbyte = page_q[7:0];
      3'd3:    wbyte = page_q[15:8];
      default: wbyte = {4'h0, page_q[19:16]};
    endcase
  end

  assign req_ready  = (st == S_IDLE);
  assign nand_ce_n  = (st == S_IDLE);
  assign nand_cle   = wr_phase && (bidx == 3'd0);
  assign nand_ale   = wr_phase && (bidx != 3'd0);
  assign nand_we_n  = (st != S_WLO);
  assign nand_re_n  = (st != S_RLO);
  assign nand_dq_o  = wbyte;
  assign nand_dq_oe = wr_phase;
  assign out_last   = out_valid && (rem == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      bidx      <= '0;
      spare_q   <= 1'b0;
      page_q    <= '0;
      rem       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          spare_q <= req_spare;
          page_q  <= req_page;
          bidx    <= '0;
          rem     <= req_spare ? RW'(1) : RW'(PAGE_SIZE);
          cnt     <= CW'(T_SU - 1);
          st      <= S_WSU;
        end
        S_WSU: if (tick) begin
          cnt <= CW'(T_WP - 1);
          st  <= S_WLO;
        end else cnt <= cnt - 1'b1;
        S_WLO: if (tick) begin
          cnt <= CW'(T_WH - 1);
          st  <= S_WHI;
        end else cnt <= cnt - 1'b1;
        S_WHI: if (!tick) cnt <= cnt - 1'b1;
        else if (bidx == 3'(LAST_B)) begin
          cnt <= CW'(T_WB - 1);
          st  <= S_TWB;
        end else begin
          bidx <= bidx + 1'b1;
          cnt  <= CW'(T_SU - 1);
          st   <= S_WSU;
        end
        S_TWB: if (tick) begin
          cnt <= CW'(WAIT_CYC - 1);
          st  <= S_WAIT;
        end else cnt <= cnt - 1'b1;
        S_WAIT: if (USE_RB != 0) begin
          if (nand_rb) begin
            cnt <= CW'(T_RP - 1);
            st  <= S_RLO;
          end
        end else if (tick) begin
          cnt <= CW'(T_RP - 1);
          st  <= S_RLO;
        end else cnt <= cnt - 1'b1;
        S_RLO: if (tick) begin
          out_data  <= nand_dq_i;
          out_valid <= 1'b1;
          rem       <= rem - 1'b1;
          cnt       <= CW'(T_REH - 1);
          st        <= S_RHI;
        end else cnt <= cnt - 1'b1;
        S_RHI: if (out_valid && out_ready && rem == '0) begin
          done <= 1'b1;
          st   <= S_IDLE;
        end else if (!tick) cnt <= cnt - 1'b1;
        else if (rem != '0 && (!out_valid || out_ready)) begin
          cnt <= CW'(T_RP - 1);
          st  <= S_RLO;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r5_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));
  a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));
  a_r10_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  a_r10_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> nand_re_n);
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r11_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid && out_ready && out_last) && req_ready);
  a_r12_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(page_q) && $stable(spare_q));
  a_r6_rb_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nand_re_n) && (USE_RB != 0) |-> $past(nand_rb));

endmodule

// File: tb/sim_nand_page_reader.sv
`timescale 1ns/1ps
module nand_model #(
  parameter int BUSY = 8,
  parameter int WP   = 2,
  parameter int RP   = 2
) (
  input  logic       clk,
  input  logic       ce_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       we_n,
  input  logic       re_n,
  input  logic [7:0] dq,
  output logic [7:0] dq_rd,
  output logic       rb
);
  logic [7:0] cmd = 8'hEE;
  logic [7:0] ab[0:4];
  int na = 0, ncmd = 0, rd_idx = 0, re_busy = 0, bad_w = 0, bad_r = 0, bcnt = 0;
  logic ale_d = 1'b0;
  time t_wl = 0, t_rl = 0, t_af = 0, t_rbr = 0, t_re1 = 0;

  assign rb = (bcnt == 0);

  always @(posedge clk) begin
    ale_d <= ale;
    if (ale_d && !ale) bcnt <= BUSY;
    else if (bcnt > 0) bcnt <= bcnt - 1;
  end
  always @(posedge rb) t_rbr = $time;
  always @(negedge ale) t_af = $time;
  always @(negedge we_n) t_wl = $time;
  always @(posedge we_n) if (ce_n === 1'b0) begin
    if ($time - t_wl != WP * 5) bad_w++;
    if (cle) begin cmd = dq; ncmd++; na = 0; rd_idx = 0; end
    else if (ale) begin if (na < 5) ab[na] = dq; na++; end
  end
  always @(negedge re_n) if (ce_n === 1'b0) begin
    t_rl = $time;
    if (rd_idx == 0) t_re1 = $time;
    if (!rb) re_busy++;
    if (cmd == 8'h50) dq_rd = ab[1][0] ? 8'h00 : 8'hFF;
    else dq_rd = ab[1] ^ ab[2] ^ 8'(rd_idx * 7 + int'(ab[0]));
    rd_idx++;
  end
  always @(posedge re_n) if (ce_n === 1'b0) begin
    if ($time - t_rl != RP * 5) bad_r++;
    #1 dq_rd = 8'h3C;
  end
endmodule

module sim_nand_page_reader;
  localparam int PS0 = 8, PS1 = 4, WAIT1 = 10, TWB = 3;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic req_valid = 0, req_spare = 0, out_ready = 1;
  logic [19:0] req_page = '0;
  logic req_ready, ce_n, cle, ale, we_n, re_n, dq_oe, rb, out_valid, out_last, done;
  logic [7:0] dq_o, dq_i, out_data;

  logic req_valid1 = 0;
  logic [19:0] req_page1 = '0;
  logic req_ready1, ce_n1, cle1, ale1, we_n1, re_n1, dq_oe1, rb1, out_valid1, out_last1, done1;
  logic [7:0] dq_o1, dq_i1, out_data1;

  nand_page_reader #(.PAGE_SIZE(PS0), .ADDR4(0), .USE_RB(1), .WAIT_CYC(5), .MARK_COL(5),
    .T_SU(1), .T_WP(2), .T_WH(1), .T_WB(TWB), .T_RP(2), .T_REH(1)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_spare(req_spare), .req_page(req_page), .nand_ce_n(ce_n), .nand_cle(cle),
    .nand_ale(ale), .nand_we_n(we_n), .nand_re_n(re_n), .nand_dq_o(dq_o),
    .nand_dq_oe(dq_oe), .nand_dq_i(dq_i), .nand_rb(rb), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last), .done(done));
  nand_model #(.BUSY(8), .WP(2), .RP(2)) m0 (.clk(clk), .ce_n(ce_n), .cle(cle), .ale(ale),
    .we_n(we_n), .re_n(re_n), .dq(dq_o), .dq_rd(dq_i), .rb(rb));

  nand_page_reader #(.PAGE_SIZE(PS1), .ADDR4(1), .USE_RB(0), .WAIT_CYC(WAIT1), .MARK_COL(5),
    .T_SU(1), .T_WP(2), .T_WH(1), .T_WB(TWB), .T_RP(2), .T_REH(1)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid1), .req_ready(req_ready1),
    .req_spare(1'b0), .req_page(req_page1), .nand_ce_n(ce_n1), .nand_cle(cle1),
    .nand_ale(ale1), .nand_we_n(we_n1), .nand_re_n(re_n1), .nand_dq_o(dq_o1),
    .nand_dq_oe(dq_oe1), .nand_dq_i(dq_i1), .nand_rb(rb1), .out_valid(out_valid1),
    .out_ready(1'b1), .out_data(out_data1), .out_last(out_last1), .done(done1));
  nand_model #(.BUSY(60), .WP(2), .RP(2)) m1 (.clk(clk), .ce_n(ce_n1), .cle(cle1), .ale(ale1),
    .we_n(we_n1), .re_n(re_n1), .dq(dq_o1), .dq_rd(dq_i1), .rb(rb1));

  int checks = 0, errors = 0;
  logic [7:0] got[0:15];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [19:0] pg, input int k);
    return pg[7:0] ^ pg[15:8] ^ 8'(k * 7);
  endfunction

  task automatic issue(input bit sp, input logic [19:0] pg);
    @(negedge clk);
    req_valid = 1; req_spare = sp; req_page = pg;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic collect(input int n, input bit stall, output int cnt_n,
                         output bit last_ok, output bit done_ok);
    int k = 0;
    int guard = 0;
    cnt_n = 0; last_ok = 1; done_ok = 0;
    while (cnt_n < n && guard < 4000) begin
      @(negedge clk);
      guard++; k++;
      out_ready = stall ? (k % 3 == 0) : 1'b1;
      if (out_valid && out_ready) begin
        got[cnt_n] = out_data;
        if (out_last != (cnt_n == n - 1)) last_ok = 0;
        cnt_n++;
      end
    end
    out_ready = 1;
    @(negedge clk);
    done_ok = done;
    @(negedge clk);
    done_ok = done_ok && !done && req_ready && !out_valid;
  endtask

  task automatic t_reset();
    check(ce_n && !cle && !ale && we_n && re_n, "R1 pins idle", {ce_n, cle, ale, we_n, re_n}, 5'b10011);
    check(req_ready && !out_valid && !done, "R1 handshake idle", {req_ready, out_valid, done}, 3'b100);
  endtask

  task automatic t_page(input logic [19:0] pg, input bit stall);
    int n, c0, bad;
    bit lok, dok;
    c0 = m0.ncmd;
    issue(0, pg);
    collect(PS0, stall, n, lok, dok);
    check(m0.ncmd == c0 + 1 && m0.cmd == 8'h00, "R2 page command", m0.cmd, 0);
    check(m0.na == 3, "R4 three address bytes", m0.na, 3);
    check(m0.ab[0] == 8'h00 && m0.ab[1] == pg[7:0] && m0.ab[2] == pg[15:8], "R3 page address",
          {m0.ab[0], m0.ab[1], m0.ab[2]}, {8'h00, pg[7:0], pg[15:8]});
    check(n == PS0 && m0.rd_idx == PS0, "R8 page length", m0.rd_idx, PS0);
    bad = 0;
    for (int k = 0; k < PS0; k++) if (got[k] != exp_byte(pg, k)) bad++;
    check(bad == 0, stall ? "R10 data under stall" : "R9 page data", bad, 0);
    check(lok, "R8 last flag", lok, 1);
    check(dok, "R11 done pulse", dok, 1);
    check(m0.re_busy == 0 && m0.t_re1 >= m0.t_rbr && m0.t_rbr - m0.t_af >= TWB * 5,
          "R6 ready/busy wait", m0.re_busy, 0);
    check(m0.bad_w == 0 && m0.bad_r == 0, "R13 strobe widths", m0.bad_w + m0.bad_r, 0);
  endtask

  task automatic t_spare(input logic [19:0] pg);
    int n;
    bit lok, dok;
    issue(1, pg);
    collect(1, 0, n, lok, dok);
    check(m0.cmd == 8'h50, "R2 spare command", m0.cmd, 8'h50);
    check(m0.ab[0] == 8'd5 && m0.ab[1] == pg[7:0] && m0.ab[2] == pg[15:8], "R3 spare column",
          m0.ab[0], 5);
    check(got[0] == (pg[0] ? 8'h00 : 8'hFF) && m0.rd_idx == 1 && lok, "R8 spare byte",
          got[0], pg[0] ? 8'h00 : 8'hFF);
    check(dok, "R11 spare done", dok, 1);
  endtask

  task automatic t_ignore();
    int n, c0;
    bit lok, dok;
    logic [19:0] pg = 20'h0_7E11;
    c0 = m0.ncmd;
    issue(0, pg);
    req_valid = 1; req_spare = 1; req_page = 20'h0_0042;
    check(!req_ready, "R12 not ready while busy", req_ready, 0);
    repeat (6) @(negedge clk);
    req_valid = 0;
    collect(PS0, 0, n, lok, dok);
    check(m0.ncmd == c0 + 1 && m0.cmd == 8'h00 && m0.ab[1] == pg[7:0], "R12 busy request ignored",
          m0.ncmd - c0, 1);
    check(got[PS0-1] == exp_byte(pg, PS0 - 1), "R12 original data", got[PS0-1], exp_byte(pg, PS0 - 1));
    repeat (10) @(negedge clk);
    check(m0.ncmd == c0 + 1 && req_ready && ce_n, "R12 no late start", m0.ncmd - c0, 1);
  endtask

  task automatic t_addr4();
    logic [19:0] pg = 20'hA_5C3E;
    int n = 0, guard = 0, bad = 0;
    @(negedge clk);
    req_valid1 = 1; req_page1 = pg;
    @(negedge clk);
    req_valid1 = 0;
    while (n < PS1 && guard < 2000) begin
      @(negedge clk);
      guard++;
      if (out_valid1) begin
        if (out_data1 != exp_byte(pg, n)) bad++;
        n++;
      end
    end
    check(m1.na == 4 && m1.ab[3] == 8'h0A, "R4 fourth address byte", m1.ab[3], 8'h0A);
    check(m1.ab[1] == 8'h3E && m1.ab[2] == 8'h5C, "R3 address order", {m1.ab[1], m1.ab[2]}, 16'h3E5C);
    check(int'((m1.t_re1 - m1.t_af) / 5) == TWB + WAIT1, "R7 fixed delay",
          int'((m1.t_re1 - m1.t_af) / 5), TWB + WAIT1);
    check(bad == 0 && n == PS1 && m1.re_busy > 0, "R7 busy line ignored", bad, 0);
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_page(20'h0_1234, 0);
    t_page(20'h0_BEEF, 1);
    t_spare(20'h0_0100);
    t_spare(20'h0_0101);
    t_ignore();
    t_addr4();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule